// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block keeps a calendar date (day of month, month and a four-digit year) in packed binary-coded decimal and advances it by exactly one day each time a single-cycle day pulse arrives. The pulse comes from separate time-of-day logic and is timed so that the date rolls over on the same clock edge at which the time of day passes midnight. Month lengths and the Gregorian leap-year rule are handled in hardware, so software never has to fix up the date.

Software sees the date as one 32-bit word behind a minimal bus slave with no address lines. A read returns the packed date. A write replaces each field whose byte is not all ones, so one field can be changed without a read-modify-write. Every strobed access is acknowledged one clock later, and the slave never stalls.

Top module: `cal_date_counter`

## Requirements
- R1: After a synchronous active-high reset the date reads 2000-01-01, that is 32'h2000_0101, and the acknowledge is low.
- R2: The read word places the BCD day in bits 5:0, the BCD month in bits 12:8, and the year in bits 29:16. Within the year, bits 23:16 hold the tens and units digits and bits 29:24 hold the thousands and hundreds digits. Bits 7:6, 15:13 and 31:30 always read as zero, and on a write the bits of these positions are dropped.
- R3: A write sets each field from its write byte unless that byte is 8'hFF, in which case the field keeps its value. The day uses byte 7:0, the month uses byte 15:8, the low year pair uses byte 23:16 and the high year pair uses byte 31:24.
- R4: A day pulse before the last day of the month increments the BCD day, with a decimal carry from 09 to 10.
- R5: After the last day of a month the day becomes 01 and the month increments. January, March, May, July, August, October and December have 31 days. April, June, September and November have 30 days.
- R6: February has 29 days when the year is divisible by 4 but not by 100, or when it is divisible by 400. Otherwise it has 28 days.
- R7: A day pulse on December 31 gives January 1 of the next year in BCD. The year field holds 0000 to 3999 and wraps from 3999 to 0000.
- R8: When a write and a day pulse occur in the same clock, the write is applied and that day pulse is dropped.
- R9: The acknowledge is high exactly one clock after a cycle in which both cycle and strobe are high, for reads and writes alike. The stall output is always low.
- R10: A day value at or beyond the month's length, such as the 31st written into February, rolls to the first of the next month on the next day pulse.
- R11: In a clock with no day pulse and no write, including a clock with a read, the date does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_wdata | input | 32 | Write data; an all-ones byte masks its field |
| bus_ack | output | 1 | Access acknowledge, one clock after the strobe |
| bus_stall | output | 1 | Always low |
| bus_rdata | output | 32 | Packed BCD date |
| day_tick | input | 1 | One-clock pulse that advances the date by one day |

## Verification
The hardest cases to reach through the ports are the rare rollovers. These are century and four-century leap decisions, the December 31 carry that ripples through all four year digits, and the 3999 wrap. Days run by at one per pulse, so waiting for them would take too long. The stimulus instead writes a date a day or two before each boundary and then pulses, running a sweep for each century case. A long run of pulses from late December crosses every month length twice, including a leap February. Masked writes and writes that coincide with a day pulse are mixed into the run. A behavioural integer model is compared with the outputs on every clock.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NUM_BYT = WORD_W / BYTE_W;
    localparam int DAY_W   = 6;
    localparam int MON_W   = 5;
    localparam int YEAR_W  = 14;
    localparam int DAY_LSB = 0;
    localparam int MON_LSB = 8;
    localparam int YR_LSB  = 16;
    localparam int YRH_LSB = 24;
    localparam int YRH_W   = YEAR_W - BYTE_W;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
    } cal_date_t;

    typedef struct packed {
        logic yr_hi;
        logic yr_lo;
        logic month;
        logic day;
    } cal_keep_t;

    function automatic logic [BYTE_W-1:0] bcd2_inc(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        if (v[3:0] >= 4'h9) r = {v[7:4] + 4'h1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'h1};
        return r;
    endfunction

    function automatic logic bcd2_div4(input logic [BYTE_W-1:0] v);
        logic r;
        if (!v[4]) r = (v[3:0] == 4'h0) || (v[3:0] == 4'h4) || (v[3:0] == 4'h8);
        else       r = (v[3:0] == 4'h2) || (v[3:0] == 4'h6);
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                    input logic leap);
        logic [BYTE_W-1:0] r;
        case (m)
            5'h02:                      r = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic logic [YEAR_W-1:0] year_inc(input logic [YEAR_W-1:0] y);
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        lo = y[BYTE_W-1:0];
        hi = {{(BYTE_W-YRH_W){1'b0}}, y[YEAR_W-1:BYTE_W]};
        if (lo == 8'h99) begin
            lo = 8'h00;
            if (hi == 8'h39) hi = 8'h00;
            else             hi = bcd2_inc(hi);
        end else begin
            lo = bcd2_inc(lo);
        end
        return {hi[YRH_W-1:0], lo};
    endfunction

    function automatic logic [WORD_W-1:0] pack_date(input cal_date_t d);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DAY_LSB +: DAY_W]  = d.day;
        w[MON_LSB +: MON_W]  = d.month;
        w[YR_LSB  +: YEAR_W] = d.year;
        return w;
    endfunction

endpackage

// File: rtl/cal_bus_port.sv
module cal_bus_port
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic              ack,
    output logic              wr_en,
    output cal_keep_t         keep
);
    logic [NUM_BYT-1:0] byte_ones;

    for (genvar g = 0; g < NUM_BYT; g++) begin : g_mask
        assign byte_ones[g] = &wdata[g*BYTE_W +: BYTE_W];
    end

    assign keep  = cal_keep_t'(byte_ones);
    assign wr_en = cyc && stb && we;

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= cyc && stb;
    end
endmodule

// File: rtl/cal_leap_detect.sv
module cal_leap_detect
    import cal_pkg::*;
(
    input  logic [YEAR_W-1:0] year,
    output logic              leap
);
    logic [BYTE_W-1:0] lo_pair;
    logic [BYTE_W-1:0] hi_pair;

    assign lo_pair = year[BYTE_W-1:0];
    assign hi_pair = {{(BYTE_W-YRH_W){1'b0}}, year[YEAR_W-1:BYTE_W]};

    always_comb begin
        if (lo_pair != 8'h00) leap = bcd2_div4(lo_pair);
        else                  leap = bcd2_div4(hi_pair);
    end
endmodule

// File: rtl/cal_day_step.sv
module cal_day_step
    import cal_pkg::*;
(
    input  cal_date_t cur,
    input  logic      leap,
    output cal_date_t nxt
);
    logic [BYTE_W-1:0] len;
    logic [BYTE_W-1:0] day_ext;
    logic [BYTE_W-1:0] mon_ext;
    logic [BYTE_W-1:0] day_up;
    logic [BYTE_W-1:0] mon_up;

    assign len     = month_len(cur.month, leap);
    assign day_ext = {{(BYTE_W-DAY_W){1'b0}}, cur.day};
    assign mon_ext = {{(BYTE_W-MON_W){1'b0}}, cur.month};
    assign day_up  = bcd2_inc(day_ext);
    assign mon_up  = bcd2_inc(mon_ext);

    always_comb begin
        nxt = cur;
        if (day_ext >= len) begin
            nxt.day = 6'h01;
            if (mon_ext >= 8'h12) begin
                nxt.month = 5'h01;
                nxt.year  = year_inc(cur.year);
            end else begin
                nxt.month = mon_up[MON_W-1:0];
            end
        end else begin
            nxt.day = day_up[DAY_W-1:0];
        end
    end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
    import cal_pkg::*;
#(
    parameter logic [YEAR_W-1:0] RST_YEAR  = 14'h2000,
    parameter logic [MON_W-1:0]  RST_MONTH = 5'h01,
    parameter logic [DAY_W-1:0]  RST_DAY   = 6'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              day_tick
);
    cal_date_t cur_q;
    cal_date_t stepped;
    cal_date_t written;
    cal_keep_t keep;
    logic      wr_en;
    logic      leap;

    cal_bus_port u_port (
        .clk   (clk),
        .rst   (rst),
        .cyc   (bus_cyc),
        .stb   (bus_stb),
        .we    (bus_we),
        .wdata (bus_wdata),
        .ack   (bus_ack),
        .wr_en (wr_en),
        .keep  (keep)
    );

    cal_leap_detect u_leap (
        .year (cur_q.year),
        .leap (leap)
    );

    cal_day_step u_step (
        .cur  (cur_q),
        .leap (leap),
        .nxt  (stepped)
    );

    always_comb begin
        written = cur_q;
        if (!keep.day)   written.day   = bus_wdata[DAY_LSB +: DAY_W];
        if (!keep.month) written.month = bus_wdata[MON_LSB +: MON_W];
        if (!keep.yr_lo) written.year[BYTE_W-1:0]      = bus_wdata[YR_LSB +: BYTE_W];
        if (!keep.yr_hi) written.year[YEAR_W-1:BYTE_W] = bus_wdata[YRH_LSB +: YRH_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{year: RST_YEAR, month: RST_MONTH, day: RST_DAY};
        end else if (wr_en) begin
            cur_q <= written;
        end else if (day_tick) begin
            cur_q <= stepped;
        end
    end

    assign bus_rdata = pack_date(cur_q);
    assign bus_stall = 1'b0;
endmodule

// File: rtl/cal_date_checker.sv
module cal_date_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_cyc,
    input logic        bus_stb,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic [31:0] bus_rdata,
    input logic        day_tick
);
    logic wr;
    assign wr = bus_cyc && bus_stb && bus_we;

    // R9
    ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_stb) |=> bus_ack);

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_cyc && bus_stb) |=> !bus_ack);

    // R11
    hold_date_chk: assert property (@(posedge clk) disable iff (rst)
        (!day_tick && !wr) |=> $stable(bus_rdata));

    // R4
    tick_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (day_tick && !wr) |=> (bus_rdata != $past(bus_rdata)));

    // R5
    month_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (day_tick && !wr) |=>
            (bus_rdata[12:8] == $past(bus_rdata[12:8]) || bus_rdata[5:0] == 6'h01));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && day_tick && bus_wdata[7:0] != 8'hFF) |=>
            (bus_rdata[5:0] == $past(bus_wdata[5:0])));

    // R3
    keep_day_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_wdata[7:0] == 8'hFF) |=> $stable(bus_rdata[5:0]));
endmodule

bind cal_date_counter cal_date_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .day_tick  (day_tick)
);

// File: tb/cal_date_counter_test.sv
module cal_date_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cyc = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic        bus_stall;
    logic [31:0] bus_rdata;
    logic        day_tick = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_year, m_month, m_day;
    logic m_ack;

    always #2 clk = ~clk;

    cal_date_counter uut (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_stall(bus_stall), .bus_rdata(bus_rdata), .day_tick(day_tick)
    );

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic logic [31:0] mkdate(input int y, input int mo, input int d);
        logic [31:0] w;
        w = '0;
        w[5:0]   = 6'(to_bcd(d));
        w[12:8]  = 5'(to_bcd(mo));
        w[23:16] = 8'(to_bcd(y % 100));
        w[29:24] = 6'(to_bcd(y / 100));
        return w;
    endfunction

    function automatic int dim(input int y, input int mo);
        bit lp;
        lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_edge(input logic cyc, stb, we, input logic [31:0] d, input logic tk);
        int lo, hi;
        if (cyc && stb && we) begin
            if (d[7:0] != 8'hFF)   m_day   = from_bcd(int'(d[5:0]));
            if (d[15:8] != 8'hFF)  m_month = from_bcd(int'(d[12:8]));
            lo = m_year % 100;
            hi = m_year / 100;
            if (d[23:16] != 8'hFF) lo = from_bcd(int'(d[23:16]));
            if (d[31:24] != 8'hFF) hi = from_bcd(int'(d[29:24]));
            m_year = hi * 100 + lo;
        end else if (tk) begin
            if (m_day >= dim(m_year, m_month)) begin
                m_day = 1;
                if (m_month >= 12) begin
                    m_month = 1;
                    m_year = (m_year + 1) % 4000;
                end else begin
                    m_month = m_month + 1;
                end
            end else begin
                m_day = m_day + 1;
            end
        end
        m_ack = cyc && stb;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic cyc, stb, we, input logic [31:0] d,
                        input logic tk, input string tag);
        @(negedge clk);
        bus_cyc = cyc; bus_stb = stb; bus_we = we; bus_wdata = d; day_tick = tk;
        @(posedge clk);
        model_edge(cyc, stb, we, d, tk);
        @(negedge clk);
        bus_cyc = 0; bus_stb = 0; bus_we = 0; day_tick = 0;
        check(tag, bus_rdata, mkdate(m_year, m_month, m_day));
        check("R9", {30'b0, bus_stall, bus_ack}, {31'b0, m_ack});
    endtask

    task automatic wr(input logic [31:0] d, input string tag);
        step(1, 1, 1, d, 0, tag);
    endtask

    task automatic tick(input string tag);
        step(0, 0, 0, '0, 1, tag);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        m_year = 2000; m_month = 1; m_day = 1; m_ack = 0;
        check("R1", bus_rdata, 32'h2000_0101);
        check("R1", {31'b0, bus_ack}, 32'h0);

        // R2 reserved bits dropped on write
        wr(32'hC024_E3D5, "R2");
        check("R2", bus_rdata, 32'h0024_0315);

        // R4 plain increments and decimal carry
        wr(mkdate(2023, 3, 8), "R4");
        tick("R4"); tick("R4");
        check("R4", bus_rdata, 32'h2023_0310);

        // R5 month lengths
        wr(mkdate(2023, 4, 30), "R5"); tick("R5");
        check("R5", bus_rdata, 32'h2023_0501);
        wr(mkdate(2023, 1, 31), "R5"); tick("R5");
        wr(mkdate(2023, 9, 30), "R5"); tick("R5");
        check("R5", bus_rdata, 32'h2023_1001);
        wr(mkdate(2023, 8, 30), "R5"); tick("R5");
        check("R5", bus_rdata, 32'h2023_0831);

        // R6 leap rules
        wr(mkdate(2023, 2, 28), "R6"); tick("R6");
        check("R6", bus_rdata, 32'h2023_0301);
        wr(mkdate(2024, 2, 28), "R6"); tick("R6");
        check("R6", bus_rdata, 32'h2024_0229);
        tick("R6");
        wr(mkdate(2100, 2, 28), "R6"); tick("R6");
        check("R6", bus_rdata, 32'h2100_0301);
        wr(mkdate(2000, 2, 28), "R6"); tick("R6");
        check("R6", bus_rdata, 32'h2000_0229);
        for (int c = 0; c < 40; c++) begin
            wr(mkdate(c * 100, 2, 28), "R6");
            tick("R6");
        end

        // R7 year rollover and wrap
        wr(mkdate(2099, 12, 31), "R7"); tick("R7");
        check("R7", bus_rdata, 32'h2100_0101);
        wr(mkdate(1999, 12, 31), "R7"); tick("R7");
        check("R7", bus_rdata, 32'h2000_0101);
        wr(mkdate(3999, 12, 31), "R7"); tick("R7");
        check("R7", bus_rdata, 32'h0000_0101);

        // R3 masked writes
        wr(mkdate(2023, 5, 5), "R3");
        wr(32'hFFFF_07FF, "R3");
        check("R3", bus_rdata, 32'h2023_0705);
        wr(32'hFFFF_FF15, "R3");
        wr(32'hFF88_FFFF, "R3");
        check("R3", bus_rdata, 32'h2088_0715);
        wr(32'h31FF_FFFF, "R3");
        check("R3", bus_rdata, 32'h3188_0715);
        wr(32'hFFFF_FFFF, "R3");

        // R8 write with tick in the same clock
        step(1, 1, 1, mkdate(2022, 6, 10), 1, "R8");
        check("R8", bus_rdata, 32'h2022_0610);
        step(1, 1, 1, 32'hFFFF_FFFF, 1, "R8");
        check("R8", bus_rdata, 32'h2022_0610);

        // R10 out-of-range day
        wr(mkdate(2023, 2, 31), "R10"); tick("R10");
        check("R10", bus_rdata, 32'h2023_0301);

        // R9 / R11 reads and partial strobes
        step(1, 1, 0, 32'h1234_5678, 0, "R11");
        step(1, 0, 0, '0, 0, "R9");
        step(0, 1, 1, mkdate(2011, 1, 1), 0, "R11");
        step(0, 0, 0, '0, 0, "R11");

        // long run across months and a leap February
        wr(mkdate(2023, 12, 25), "R5");
        for (int i = 0; i < 820; i++) begin
            if (i % 7 == 3) step(0, 0, 0, '0, 0, "R11");
            tick(i % 2 == 0 ? "R5" : "R6");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule